// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that must be serviced by software. It has a small register file with four registers behind a simple write strobe and a combinational read port. The key register accepts 16-bit command words. One word starts the watchdog and another refreshes it. A third word opens the two configuration registers for writing, and a fourth closes them. Any other word does nothing. A free-running clock divider produces prescaled ticks. While the watchdog runs, a 12-bit down-counter moves one step per tick. When the counter expires, the block raises a reset request for one clock.

Configuration writes do not take effect at once. Each accepted write is first held in a shadow register and raises a pending flag in the status register. After a fixed number of prescaled ticks, the value is copied into the active register and the flag clears. Once the watchdog has been started, no key word can stop it. Only the block's reset returns it to idle.

Register addresses are 0 for the key, 1 for the divider code, 2 for the reload value and 3 for status. Writes to address 3 are ignored.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, rst_req is 0, a read of address 1 returns 0, a read of address 2 returns 0xFFF and a read of address 3 returns 0.
- R2: While write access is closed, writes to address 1 or address 2 do not change the value read back and set no status flag.
- R3: Key word 0x5555 opens write access. Key word 0x0000 closes it, and key word 0xAAAA also closes it.
- R4: No reset request is raised before key word 0xCCCC has been written. That word loads the counter from the active reload value and starts counting.
- R5: Divider code c (bits 2:0 of address 1) gives one tick every 4·2^c clocks for c from 0 to 6. Code 7 gives one tick every 256 clocks. The counter steps down once per tick.
- R6: A tick that finds the counter at zero raises rst_req for exactly one clock and reloads the counter. Without refreshes, successive requests are (reload+1)·period clocks apart.
- R7: Key word 0xAAAA reloads the counter from the active reload value, so regular refreshes keep rst_req low.
- R8: Once started, the watchdog keeps running whatever key words follow. Unrecognised key words change neither the counter, nor the access state, nor the configuration.
- R9: Status bit 0 is set by an accepted divider-code write and bit 1 by an accepted reload write. Each bit clears after SYNC_TICKS ticks, and only then does the new value take effect. A further write restarts the wait.
- R10: A refresh in the same clock as an expiring tick wins: the counter is reloaded and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 key, 1 divider code, 2 reload, 3 status) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| rst_req | output | 1 | One-clock reset request on expiry |

## Verification
The assertions assume that the write strobe carries a single address per clock and that wr_addr and wr_data are stable at the sampling edge. They also assume SYNC_TICKS is at least one, so that a pending flag can only fall on a tick. The bench drives every input on the falling edge and holds each write for exactly one clock. It sweeps refresh offsets against the expiry tick, which covers the case where a refresh and an expiry land in the same clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W = 16;

  typedef enum logic [1:0] {
    REG_KEY    = 2'd0,
    REG_DIV    = 2'd1,
    REG_RELOAD = 2'd2,
    REG_STATUS = 2'd3
  } wdt_reg_e;

  localparam logic [KEY_W-1:0] CMD_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] CMD_FEED  = 16'hAAAA;
  localparam logic [KEY_W-1:0] CMD_OPEN  = 16'h5555;
  localparam logic [KEY_W-1:0] CMD_CLOSE = 16'h0000;

  typedef enum logic [2:0] {
    KC_NONE,
    KC_START,
    KC_FEED,
    KC_OPEN,
    KC_CLOSE
  } key_cmd_e;
endpackage

// File: rtl/wdt_keyctl.sv
module wdt_keyctl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             access_open,
  output logic             started,
  output logic             start_p,
  output logic             feed_p
);
  key_cmd_e cmd;
  logic     open_n, run_n;

  always_comb begin
    cmd = KC_NONE;
    if (key_wr) begin
      unique case (key_val)
        CMD_START: cmd = KC_START;
        CMD_FEED:  cmd = KC_FEED;
        CMD_OPEN:  cmd = KC_OPEN;
        CMD_CLOSE: cmd = KC_CLOSE;
        default:   cmd = KC_NONE;
      endcase
    end
  end

  always_comb begin
    start_p = (cmd == KC_START) && !started;
    feed_p  = (cmd == KC_FEED);
    run_n   = started | start_p;
    open_n  = access_open;
    if (cmd == KC_OPEN) open_n = 1'b1;
    if (cmd == KC_CLOSE || cmd == KC_FEED) open_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_open <= 1'b0;
      started     <= 1'b0;
    end else begin
      access_open <= open_n;
      started     <= run_n;
    end
  end
endmodule

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  localparam int DIV_W = 1 << PS_W;
  localparam int MAXC  = DIV_W - 2;

  logic [DIV_W-1:0] div_q, div_n, lim;
  int               code_eff;

  always_comb begin
    code_eff = (int'(code) > MAXC) ? MAXC : int'(code);
    lim      = {DIV_W{1'b1}} >> (MAXC - code_eff);
    tick     = (div_q >= lim);
    div_n    = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/wdt_cfg_sync.sv
module wdt_cfg_sync #(
  parameter int          W          = 12,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter int          SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int LW = $clog2(SYNC_TICKS + 1);

  logic [W-1:0]  shadow_n, active_n;
  logic          busy_n;
  logic [LW-1:0] left_q, left_n;

  always_comb begin
    shadow_n = shadow;
    active_n = active;
    busy_n   = busy;
    left_n   = left_q;
    if (wr) begin
      shadow_n = wdata;
      busy_n   = 1'b1;
      left_n   = LW'(SYNC_TICKS);
    end else if (busy && tick) begin
      if (left_q == LW'(1)) begin
        active_n = shadow;
        busy_n   = 1'b0;
        left_n   = '0;
      end else begin
        left_n = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      busy   <= 1'b0;
      left_q <= '0;
    end else begin
      shadow <= shadow_n;
      active <= active_n;
      busy   <= busy_n;
      left_q <= left_n;
    end
  end
endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             started,
  input  logic             start_p,
  input  logic             feed_p,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             req_n;

  always_comb begin
    cnt_n = cnt_q;
    req_n = 1'b0;
    if (start_p || feed_p) begin
      cnt_n = reload;
    end else if (started && tick) begin
      if (cnt_q == '0) begin
        cnt_n = reload;
        req_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      rst_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      rst_req <= req_n;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PS_W       = 3,
  parameter int DATA_W     = 16,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] RLD_RST = {CNT_W{1'b1}};
  localparam logic [PS_W-1:0]  DIV_RST = '0;

  logic             access_open, started, start_p, feed_p, tick;
  logic             key_wr, ps_wr, rl_wr;
  logic [PS_W-1:0]  ps_shadow, ps_active;
  logic [CNT_W-1:0] rl_shadow, rl_active;
  logic             ps_busy, rl_busy;

  always_comb begin
    key_wr = wr_en && (wr_addr == REG_KEY);
    ps_wr  = wr_en && (wr_addr == REG_DIV)    && access_open;
    rl_wr  = wr_en && (wr_addr == REG_RELOAD) && access_open;
  end

  wdt_keyctl u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(wr_data[KEY_W-1:0]),
    .access_open(access_open), .started(started), .start_p(start_p), .feed_p(feed_p)
  );

  wdt_divider #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .code(ps_active), .tick(tick)
  );

  wdt_cfg_sync #(.W(PS_W), .RST_VAL(DIV_RST), .SYNC_TICKS(SYNC_TICKS)) u_ps_sync (
    .clk(clk), .rst_n(rst_n), .wr(ps_wr), .wdata(wr_data[PS_W-1:0]), .tick(tick),
    .shadow(ps_shadow), .active(ps_active), .busy(ps_busy)
  );

  wdt_cfg_sync #(.W(CNT_W), .RST_VAL(RLD_RST), .SYNC_TICKS(SYNC_TICKS)) u_rl_sync (
    .clk(clk), .rst_n(rst_n), .wr(rl_wr), .wdata(wr_data[CNT_W-1:0]), .tick(tick),
    .shadow(rl_shadow), .active(rl_active), .busy(rl_busy)
  );

  wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .started(started), .start_p(start_p), .feed_p(feed_p),
    .tick(tick), .reload(rl_active), .rst_req(rst_req)
  );

  always_comb begin
    unique case (rd_addr)
      REG_DIV:    rd_data = DATA_W'(ps_shadow);
      REG_RELOAD: rd_data = DATA_W'(rl_shadow);
      REG_STATUS: rd_data = DATA_W'({rl_busy, ps_busy});
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import wdt_pkg::*;
#(
  parameter int PS_W   = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rst_req,
  input logic              started,
  input logic              access_open,
  input logic [PS_W-1:0]   ps_shadow,
  input logic              ps_busy,
  input logic              tick
);
  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !rst_req);

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> started);

  // R2
  locked_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DIV && !access_open) |=> $stable(ps_shadow));

  // R3
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_KEY && (wr_data[15:0] == CMD_CLOSE || wr_data[15:0] == CMD_FEED))
      |=> !access_open);

  // R9
  busy_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps_busy) |-> $past(tick));

  // R10
  feed_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_KEY && wr_data[15:0] == CMD_FEED) |=> !rst_req);
endmodule

bind keyed_wdt keyed_wdt_chk #(.PS_W(PS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rst_req(rst_req), .started(started), .access_open(access_open),
  .ps_shadow(ps_shadow), .ps_busy(ps_busy), .tick(tick)
);

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd3;
  logic [15:0] rd_data;
  logic        rst_req;

  always #10 clk = ~clk;

  keyed_wdt #(.SYNC_TICKS(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
  );

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference
  int m_div, m_pact, m_psh, m_pb, m_pl, m_ract, m_rsh, m_rb, m_rl, m_cnt;
  int m_open, m_run, m_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_pact = 0; m_psh = 0; m_pb = 0; m_pl = 0;
      m_ract = 4095; m_rsh = 4095; m_rb = 0; m_rl = 0; m_cnt = 4095;
      m_open = 0; m_run = 0; m_rst = 0;
    end else begin
      int per, tk, is_key, start, feed, pw, rw;
      per    = 4 << ((m_pact == 7) ? 6 : m_pact);
      tk     = (m_div >= per - 1);
      m_div  = tk ? 0 : m_div + 1;
      is_key = wr_en && wr_addr == 0;
      start  = is_key && wr_data == 16'hCCCC && !m_run;
      feed   = is_key && wr_data == 16'hAAAA;
      pw     = wr_en && wr_addr == 1 && m_open;
      rw     = wr_en && wr_addr == 2 && m_open;
      m_rst  = 0;
      if (start || feed) m_cnt = m_ract;
      else if (m_run && tk) begin
        if (m_cnt == 0) begin m_cnt = m_ract; m_rst = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (start) m_run = 1;
      if (is_key && wr_data == 16'h5555) m_open = 1;
      if (is_key && (wr_data == 16'h0000 || feed)) m_open = 0;
      if (pw) begin m_psh = wr_data & 7; m_pb = 1; m_pl = SYNC; end
      else if (m_pb && tk) begin
        if (m_pl == 1) begin m_pact = m_psh; m_pb = 0; end else m_pl--;
      end
      if (rw) begin m_rsh = wr_data & 12'hFFF; m_rb = 1; m_rl = SYNC; end
      else if (m_rb && tk) begin
        if (m_rl == 1) begin m_ract = m_rsh; m_rb = 0; end else m_rl--;
      end
    end
  end

  function automatic int m_rd(input int a);
    case (a)
      1: return m_psh;
      2: return m_rsh;
      3: return m_rb * 2 + m_pb;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] wa, input logic [15:0] wd);
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    cyc++;
    chk({phase, " rst_req"}, int'(rst_req), m_rst);
    chk({phase, " rd_data"}, int'(rd_data), m_rd(int'(rd_addr)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
    rd_addr = a; #1;
    chk(tag, int'(rd_data), exp);
    rd_addr = 2'd3;
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 5000; i++) begin
      step(1'b0, 2'd0, 16'h0);
      if (rst_req) begin at = cyc; break; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (m_pb == 0 && m_rb == 0) break;
      step(1'b0, 2'd0, 16'h0);
    end
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p1, p2, p3, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 rst_req", int'(rst_req), 0);
    rd_chk("R1 div", 2'd1, 0);
    rd_chk("R1 reload", 2'd2, 12'hFFF);
    rd_chk("R1 status", 2'd3, 0);

    // R2 locked writes ignored
    phase = "R2";
    step(1'b1, 2'd1, 16'h5);
    step(1'b1, 2'd2, 16'h123);
    rd_chk("R2 div", 2'd1, 0);
    rd_chk("R2 reload", 2'd2, 12'hFFF);
    rd_chk("R2 status", 2'd3, 0);

    // R9 accepted writes set flags, clear after ticks
    phase = "R9";
    step(1'b1, 2'd0, 16'h5555);
    step(1'b1, 2'd2, 16'h3);
    rd_chk("R9 status reload pending", 2'd3, 2);
    step(1'b1, 2'd1, 16'h0);
    rd_chk("R9 status both pending", 2'd3, 3);
    wait_idle();
    rd_chk("R9 status cleared", 2'd3, 0);
    rd_chk("R9 reload value", 2'd2, 3);

    // R3 close by 0x0000 and by 0xAAAA; unrecognised key does not open
    phase = "R3";
    step(1'b1, 2'd0, 16'h0000);
    step(1'b1, 2'd2, 16'h9);
    rd_chk("R3 close 0000", 2'd2, 3);
    step(1'b1, 2'd0, 16'h5555);
    step(1'b1, 2'd0, 16'hAAAA);
    step(1'b1, 2'd2, 16'h9);
    rd_chk("R3 close AAAA", 2'd2, 3);
    phase = "R8";
    step(1'b1, 2'd0, 16'h1234);
    step(1'b1, 2'd1, 16'h4);
    rd_chk("R8 bad key keeps lock", 2'd1, 0);

    // R4 no request before start
    phase = "R4";
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      step(1'b0, 2'd0, 16'h0);
      if (rst_req) seen++;
    end
    chk("R4 idle requests", seen, 0);
    step(1'b1, 2'd0, 16'hCCCC);

    // R6 expiry interval with reload 3, divide by 4
    phase = "R6";
    wait_pulse(p1);
    wait_pulse(p2);
    chk("R6 interval", p2 - p1, 16);

    // R5 divider code 2 then code 7
    phase = "R5";
    step(1'b1, 2'd0, 16'h5555);
    step(1'b1, 2'd1, 16'h2);
    step(1'b1, 2'd0, 16'h0000);
    wait_pulse(p1); wait_pulse(p2); wait_pulse(p3);
    chk("R5 code2 interval", p3 - p2, 64);
    step(1'b1, 2'd0, 16'h5555);
    step(1'b1, 2'd1, 16'h7);
    step(1'b1, 2'd0, 16'h0000);
    wait_pulse(p1); wait_pulse(p2); wait_pulse(p3);
    chk("R5 code7 interval", p3 - p2, 1024);

    // R7 periodic refresh prevents expiry
    phase = "R7";
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 2'd0, 16'hAAAA);
      for (int i = 0; i < 500; i++) begin
        step(1'b0, 2'd0, 16'h0);
        if (rst_req) seen++;
      end
    end
    chk("R7 refreshed requests", seen, 0);

    // R8 keys cannot stop it
    phase = "R8";
    step(1'b1, 2'd0, 16'h5555);
    step(1'b1, 2'd1, 16'h0);
    step(1'b1, 2'd0, 16'h0000);
    wait_idle();
    step(1'b1, 2'd0, 16'h1234);
    step(1'b1, 2'd0, 16'hCCCC);
    step(1'b1, 2'd0, 16'h0000);
    wait_pulse(p1);
    wait_pulse(p2);
    chk("R8 still running", p2 - p1, 16);

    // R10 refresh swept across the expiring tick
    phase = "R10";
    for (int off = 0; off < 20; off++) begin
      wait_pulse(p1);
      idle(off);
      step(1'b1, 2'd0, 16'hAAAA);
    end
    chk("R10 completed sweep", int'(p1 > 0), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule